// File: doc/BRIEF.md
# Processor Reset and Clock-Ramp Sequencer

This block sequences a processor core out of reset. It watches an active-low reset and a power-good input. Once both allow it, the block raises the core clock in stages. It drives a PLL input-divider code and an output-divider code from a computed ladder of settings, lowest frequency first. Each setting is held for a fixed lock interval so the PLL can settle before the next step.

When the ramp is complete, the sequencer waits for synchronous pulses on a forward-reset input:

- The first pulse fires a one-cycle strobe that starts self-test and boot-ROM load.
- After the self-test engine reports done, a second pulse fires a one-cycle strobe that starts clock-forwarding interface setup.
- When that logic reports done, the core is in normal run.

A sleep request in run walks the dividers back down one lock interval per step and parks the core asleep. A wake request re-runs the ramp from the lowest step and returns straight to run.

The PLL, the self-test engine, the ROM loader and the clock-forwarding logic are outside the block. It only supplies divider codes and start strobes, and it takes done indications back.

Top module: `rst_clk_ramp_seq`

## Requirements
- R1: While `rst_n` is low, the block is in its initial state at once, without waiting for a clock edge. In this state `in_div` = STEPS, `out_div` = 2*STEPS, and `bist_start`, `cfi_start`, `running` and `asleep` are all 0.
- R2: At any clock edge where `pwr_ok` is low, the block returns to that same initial state. It does not advance while `pwr_ok` stays low.
- R3: The ramp uses step index s from 0 to STEPS-1, and step s drives `in_div` = STEPS-s and `out_div` = 2*(STEPS-s).
  - The first edge with `rst_n` and `pwr_ok` both high leaves the idle state.
  - From that edge, each step is held for exactly LOCK_CYCLES clock edges.
- R4: A `fwd_rst` pulse seen while the ramp is still running produces no start strobe.
- R5: After the ramp, the first `fwd_rst` high at an edge makes `bist_start` high for exactly the one cycle after that edge.
- R6: The block accepts a `fwd_rst` pulse for `cfi_start` only after `bist_done`, and `cfi_start` is a one-cycle pulse. A `fwd_rst` pulse while the block still waits for `bist_done` is ignored.
- R7: `running` rises in the cycle after the edge that sees `cfi_done` in the clock-forward setup phase.
- R8: In run, `sleep_req` steps the dividers down one step at that edge, then one more step every LOCK_CYCLES edges. Step 0 is then held for LOCK_CYCLES edges, after which `asleep` rises. A `sleep_req` outside run is ignored.
- R9: In sleep, `fwd_rst` is ignored. `wake_req` restarts the ramp at step 0 with the same timing as R3 and then raises `running` directly, without a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good; low forces the initial state |
| fwd_rst | input | 1 | Synchronous forward-reset pulse that opens the later phases |
| bist_done | input | 1 | Self-test and ROM load finished |
| cfi_done | input | 1 | Clock-forwarding interface setup finished |
| sleep_req | input | 1 | Request to ramp down and sleep |
| wake_req | input | 1 | Request to leave sleep |
| in_div | output | DIV_W | PLL input-divider code |
| out_div | output | DIV_W | PLL output-divider code |
| bist_start | output | 1 | One-cycle start for self-test and ROM load |
| cfi_start | output | 1 | One-cycle start for clock-forwarding setup |
| running | output | 1 | Normal run phase |
| asleep | output | 1 | Sleep phase reached |

## Verification
The bench builds the block with STEPS=3, LOCK_CYCLES=5 and DIV_W=4. With these values a full power-up, a sleep descent and a wake ramp each last only a few dozen cycles, so every lock-interval boundary can be compared on every clock. The odd, small lock count makes an off-by-one in the lock counter visible as a step edge one cycle early or late. Three steps are enough for the descent to pass through an intermediate step before parking at step 0.

// File: rtl/rst_clk_ramp_seq.sv
`timescale 1ns/1ps
module rst_clk_ramp_seq #(
  parameter int STEPS       = 4,
  parameter int LOCK_CYCLES = 256,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             fwd_rst,
  input  logic             bist_done,
  input  logic             cfi_done,
  input  logic             sleep_req,
  input  logic             wake_req,
  output logic [DIV_W-1:0] in_div,
  output logic [DIV_W-1:0] out_div,
  output logic             bist_start,
  output logic             cfi_start,
  output logic             running,
  output logic             asleep
);
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LOCK_CYCLES - 1);
  localparam logic [DIV_W-1:0] IN_TOP = DIV_W'(STEPS);
  localparam logic [DIV_W-1:0] OUT_TOP = DIV_W'(2 * STEPS);

  typedef enum logic [3:0] {
    S_IDLE, S_UP, S_WFWD1, S_BIST, S_WFWD2, S_CFI, S_RUN, S_DOWN, S_SLEEP
  } state_t;

  state_t        st;
  logic [SW-1:0] step;
  logic [CW-1:0] cnt;
  logic          warm;
  logic          lock_done;

  assign lock_done = (cnt == LAST_CNT);
  assign in_div    = IN_TOP - DIV_W'(step);
  assign out_div   = OUT_TOP - (DIV_W'(step) << 1);
  assign running   = (st == S_RUN);
  assign asleep    = (st == S_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      step <= '0;
      cnt <= '0;
      warm <= 1'b0;
      bist_start <= 1'b0;
      cfi_start <= 1'b0;
    end else if (!pwr_ok) begin
      st <= S_IDLE;
      step <= '0;
      cnt <= '0;
      warm <= 1'b0;
      bist_start <= 1'b0;
      cfi_start <= 1'b0;
    end else begin
      bist_start <= 1'b0;
      cfi_start <= 1'b0;
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          st <= S_UP;
          cnt <= '0;
        end
        S_UP:
          if (lock_done) begin
            cnt <= '0;
            if (step == LAST_STEP) st <= warm ? S_RUN : S_WFWD1;
            else step <= step + 1'b1;
          end
        S_WFWD1:
          if (fwd_rst) begin
            st <= S_BIST;
            bist_start <= 1'b1;
          end
        S_BIST:
          if (bist_done) st <= S_WFWD2;
        S_WFWD2:
          if (fwd_rst) begin
            st <= S_CFI;
            cfi_start <= 1'b1;
          end
        S_CFI:
          if (cfi_done) st <= S_RUN;
        S_RUN:
          if (sleep_req) begin
            st <= S_DOWN;
            cnt <= '0;
            if (step != '0) step <= step - 1'b1;
          end
        S_DOWN:
          if (lock_done) begin
            cnt <= '0;
            if (step == '0) begin
              st <= S_SLEEP;
              warm <= 1'b1;
            end else begin
              step <= step - 1'b1;
            end
          end
        S_SLEEP:
          if (wake_req) begin
            st <= S_UP;
            cnt <= '0;
            step <= '0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: a power-good drop clears to the initial outputs at the next edge
  assert_pwr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (in_div == IN_TOP && out_div == OUT_TOP && !running && !asleep
                 && !bist_start && !cfi_start));

  // R3: dividers hold while a lock interval is still counting
  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !pwr_ok)
    (st == S_UP && !lock_done) |=> ($stable(in_div) && $stable(out_div)));

  // R4: forward-reset during the ramp starts nothing
  assert_ramp_ignores_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n || !pwr_ok)
    (st == S_UP && fwd_rst) |=> (!bist_start && !cfi_start));

  // R5: self-test strobe is one cycle and follows a forward-reset pulse
  assert_bist_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |=> !bist_start);
  assert_bist_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |-> $past(fwd_rst));

  // R6: clock-forward strobe is one cycle and never overlaps the other
  assert_cfi_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfi_start |=> !cfi_start);
  assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bist_start && cfi_start));

  // R7: run is entered only on a done report or at the end of a wake ramp
  assert_run_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(cfi_done) || $past(warm)));

  // R8: sleep is reached only at the lowest-frequency step
  assert_sleep_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (in_div == IN_TOP));
endmodule

// File: tb/sim_rst_clk_ramp_seq.sv
`timescale 1ns/1ps
module sim_rst_clk_ramp_seq;
  localparam int STEPS = 3;
  localparam int LOCK = 5;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, fwd_rst, bist_done, cfi_done, sleep_req, wake_req;
  logic [DW-1:0] in_div, out_div;
  logic bist_start, cfi_start, running, asleep;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rst_clk_ramp_seq #(.STEPS(STEPS), .LOCK_CYCLES(LOCK), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .fwd_rst(fwd_rst),
    .bist_done(bist_done), .cfi_done(cfi_done), .sleep_req(sleep_req),
    .wake_req(wake_req), .in_div(in_div), .out_div(out_div),
    .bist_start(bist_start), .cfi_start(cfi_start), .running(running),
    .asleep(asleep));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase code, step, remaining lock cycles
  int m_ph, m_stp, m_left;
  bit m_warm, m_bs, m_cs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pwr_ok) begin
      m_ph = 0; m_stp = 0; m_left = 0; m_warm = 0; m_bs = 0; m_cs = 0;
    end else begin
      m_bs = 0; m_cs = 0;
      case (m_ph)
        0: begin m_ph = 1; m_left = LOCK; end
        1: begin
          m_left--;
          if (m_left == 0) begin
            if (m_stp == STEPS - 1) m_ph = m_warm ? 6 : 2;
            else begin m_stp++; m_left = LOCK; end
          end
        end
        2: if (fwd_rst) begin m_ph = 3; m_bs = 1; end
        3: if (bist_done) m_ph = 4;
        4: if (fwd_rst) begin m_ph = 5; m_cs = 1; end
        5: if (cfi_done) m_ph = 6;
        6: if (sleep_req) begin m_ph = 7; m_left = LOCK; if (m_stp > 0) m_stp--; end
        7: begin
          m_left--;
          if (m_left == 0) begin
            if (m_stp == 0) begin m_ph = 8; m_warm = 1; end
            else begin m_stp--; m_left = LOCK; end
          end
        end
        8: if (wake_req) begin m_ph = 1; m_stp = 0; m_left = LOCK; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    check("R3 in_div", int'(in_div), STEPS - m_stp);
    check("R3 out_div", int'(out_div), 2 * (STEPS - m_stp));
    check("R5 bist_start", int'(bist_start), int'(m_bs));
    check("R6 cfi_start", int'(cfi_start), int'(m_cs));
    check("R7 running", int'(running), int'(m_ph == 6));
    check("R8 asleep", int'(asleep), int'(m_ph == 8));
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1; pwr_ok = 0; fwd_rst = 0; bist_done = 0; cfi_done = 0;
    sleep_req = 0; wake_req = 0;
    #1 rst_n = 0;
    cyc(3);
    check("R1 reset in_div", int'(in_div), STEPS);
    check("R1 reset out_div", int'(out_div), 2 * STEPS);
    check("R1 reset strobes", int'({bist_start, cfi_start, running, asleep}), 0);

    rst_n = 1;
    cyc(4);
    check("R2 no advance without pwr_ok", int'(in_div), STEPS);

    pwr_ok = 1;
    cyc(LOCK);
    check("R3 step0 held", int'(in_div), STEPS);
    cyc(1);
    check("R3 step1 in_div", int'(in_div), STEPS - 1);
    check("R3 step1 out_div", int'(out_div), 2 * (STEPS - 1));

    fwd_rst = 1; cyc(1); fwd_rst = 0; cyc(1);
    check("R4 fwd during ramp", int'(bist_start), 0);

    pwr_ok = 0; cyc(1);
    check("R2 pwr drop clears", int'(in_div), STEPS);
    pwr_ok = 1; cyc(LOCK);
    check("R2 ramp restarted", int'(in_div), STEPS);
    cyc(1);
    check("R2 ramp restarted step1", int'(in_div), STEPS - 1);

    while (m_ph != 2) cyc(1);
    check("R4 ramp end no strobe", int'(bist_start), 0);

    sleep_req = 1; cyc(1); sleep_req = 0; cyc(1);
    check("R8 sleep outside run ignored", int'(in_div), 1);

    fwd_rst = 1; cyc(1); fwd_rst = 0;
    check("R5 bist_start pulse", int'(bist_start), 1);
    cyc(1);
    check("R5 bist_start single", int'(bist_start), 0);

    fwd_rst = 1; cyc(1); fwd_rst = 0; cyc(1);
    check("R6 fwd before bist_done ignored", int'(cfi_start), 0);

    bist_done = 1; cyc(1); bist_done = 0;
    fwd_rst = 1; cyc(1); fwd_rst = 0;
    check("R6 cfi_start pulse", int'(cfi_start), 1);
    cyc(1);
    check("R6 cfi_start single", int'(cfi_start), 0);

    cyc(3);
    check("R7 not running before done", int'(running), 0);
    cfi_done = 1; cyc(1); cfi_done = 0;
    check("R7 running after done", int'(running), 1);

    sleep_req = 1; cyc(1); sleep_req = 0;
    check("R8 first down step", int'(in_div), 2);
    check("R8 run left", int'(running), 0);
    cyc((STEPS - 1) * LOCK - 1);
    check("R8 not yet asleep", int'(asleep), 0);
    cyc(1);
    check("R8 asleep", int'(asleep), 1);
    check("R8 lowest pair", int'(in_div), STEPS);

    fwd_rst = 1; cyc(1); fwd_rst = 0; cyc(1);
    check("R9 fwd in sleep ignored", int'(bist_start), 0);
    check("R9 still asleep", int'(asleep), 1);

    wake_req = 1; cyc(1); wake_req = 0;
    check("R9 wake left sleep", int'(asleep), 0);
    check("R9 wake at step0", int'(in_div), STEPS);
    cyc(STEPS * LOCK - 1);
    check("R9 not yet running", int'(running), 0);
    cyc(1);
    check("R9 running after wake ramp", int'(running), 1);

    rst_n = 0; #0.5;
    check("R1 async reset running", int'(running), 0);
    check("R1 async reset in_div", int'(in_div), STEPS);
    cyc(2);
    rst_n = 1;
    cyc(6);
    check("R3 after re-reset step1", int'(in_div), STEPS - 1);
    summary();
  end
endmodule